// File: doc/BRIEF.md
# Serial Clock High/Low Period Generator

This block produces the serial clock of a two-wire bus master. The line is open-drain: the block either pulls it low or releases it and lets the pull-up, or a slow target, bring it high. Two pairs of high-count and low-count values are supplied, one pair for standard speed and one for fast speed. A two-bit speed code picks the pair. While the enable input is high the generator alternates a counted low phase and a counted high phase. It gives the byte engine a one-cycle tick at each falling and each rising edge of the clock.

The low phase is timed from the cycle in which the block starts to pull the line low. The high phase is timed only once the synchronised line has been seen high, so a target that holds the line low stretches the period. The high phase also carries a fixed overhead of eight cycles: two synchroniser stages plus internal filter time. The selected counts are captured when the generator starts, so new values take effect only after a disable and re-enable. Counts below six are raised to six.

Top module: `scl_period_gen`

## Requirements
- R1: Out of reset, and from the cycle after `gen_en` is sampled low, `scl_drive_low`, `bit_tick_fall` and `bit_tick_rise` are all 0.
- R2: In the cycle after `gen_en` is first sampled high, `scl_drive_low` is 1.
- R3: Each low phase keeps `scl_drive_low` at 1 for exactly Leff+1 consecutive cycles, where Leff is the selected, floored low count.
- R4: When the line follows the drive with no delay, each high phase keeps `scl_drive_low` at 0 for exactly Heff+8 cycles, where Heff is the selected, floored high count.
- R5: If the line is held low for S extra cycles after release, the high phase lasts Heff+8+S cycles. `bit_tick_rise` comes in the third cycle after the first cycle the line reads high.
- R6: Speed code 2'b10 selects the fast pair. Every other code (2'b01, 2'b00, 2'b11) selects the standard pair.
- R7: A count value below 6 behaves exactly as 6.
- R8: Changes to the count inputs or to the speed code while `gen_en` stays high have no effect until the generator is disabled and enabled again.
- R9: `bit_tick_fall` is a one-cycle pulse in the first cycle of every low phase. `bit_tick_rise` is a one-cycle pulse in the first counted high cycle. The two ticks never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gen_en | input | 1 | Runs the generator while high |
| speed_code | input | 2 | 2'b10 fast pair, otherwise standard pair |
| std_hi_cnt | input | 16 | Standard-speed high count |
| std_lo_cnt | input | 16 | Standard-speed low count |
| fast_hi_cnt | input | 16 | Fast-speed high count |
| fast_lo_cnt | input | 16 | Fast-speed low count |
| scl_sense | input | 1 | Raw level of the clock line |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| bit_tick_fall | output | 1 | One-cycle pulse at the start of a low phase |
| bit_tick_rise | output | 1 | One-cycle pulse when high counting starts |

## Verification
A wrong phase counter, a wrong captured count or a wrong synchroniser depth shows up on `scl_drive_low`. It gives a low or high phase that is too long or too short, and the error is visible in the first bit period after enable, so at most a few dozen cycles in. A wrong floor or speed decode shows as the wrong period for that configuration. A missed capture shows only after counts change mid-run, so the bench changes them while running. Because a reference model is compared every cycle, a tick that is misplaced by one cycle, or an enable that releases the line a cycle late, is reported in the cycle it happens.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  localparam logic [1:0] SPEED_FAST = 2'b10;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic synced
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= raw_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/scl_cnt_sel.sv
module scl_cnt_sel
  import scl_gen_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       speed_code,
  input  logic [CNT_W-1:0] std_hi,
  input  logic [CNT_W-1:0] std_lo,
  input  logic [CNT_W-1:0] fast_hi,
  input  logic [CNT_W-1:0] fast_lo,
  output logic [CNT_W-1:0] hi_lim,
  output logic [CNT_W-1:0] lo_lim
);
  localparam int NPAIR = 2;
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_CNT);

  logic             use_fast;
  logic [CNT_W-1:0] pick   [NPAIR];
  logic [CNT_W-1:0] shadow [NPAIR];

  assign use_fast = (speed_code == SPEED_FAST);
  assign pick[0]  = use_fast ? fast_hi : std_hi;
  assign pick[1]  = use_fast ? fast_lo : std_lo;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic [CNT_W-1:0] floored;
    assign floored = (pick[g] < FLOOR) ? FLOOR : pick[g];
    always_ff @(posedge clk) begin
      if (!rst_n)    shadow[g] <= FLOOR;
      else if (load) shadow[g] <= floored;
    end
  end

  assign hi_lim = shadow[0];
  assign lo_lim = shadow[1];

  a_r8_hold_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(!load)) |-> ($stable(hi_lim) && $stable(lo_lim)));
  a_r7_floor_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_lim >= FLOOR) && (lo_lim >= FLOOR));
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_gen_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int HI_OVH      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             line_hi,
  input  logic [CNT_W-1:0] hi_lim,
  input  logic [CNT_W-1:0] lo_lim,
  output logic             drive_low,
  output logic             tick_fall,
  output logic             tick_rise,
  output logic             idle
);
  localparam int CW      = CNT_W + 1;
  localparam int HI_TAIL = HI_OVH - SYNC_STAGES - 1;

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lo_end;
  logic [CW-1:0] hi_end;

  assign lo_end = {1'b0, lo_lim};
  assign hi_end = {1'b0, hi_lim} + CW'(HI_TAIL - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          ph  <= PH_LOW;
          cnt <= '0;
        end
        PH_LOW: begin
          if (cnt == lo_end) begin
            ph  <= PH_WAIT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_WAIT: begin
          if (line_hi) begin
            ph  <= PH_HIGH;
            cnt <= '0;
          end
        end
        PH_HIGH: begin
          if (cnt == hi_end) begin
            ph  <= PH_LOW;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          ph  <= PH_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end

  assign drive_low = (ph == PH_LOW);
  assign tick_fall = (ph == PH_LOW)  && (cnt == '0);
  assign tick_rise = (ph == PH_HIGH) && (cnt == '0);
  assign idle      = (ph == PH_IDLE);

  a_r1_release_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !drive_low);
  a_r9_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tick_fall, tick_rise}));
  a_r9_fall_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |-> drive_low);
  a_r5_rise_after_line: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |-> $past(line_hi));
  a_r3_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> (cnt <= lo_end));
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MIN_CNT     = 6,
  parameter int SYNC_STAGES = 2,
  parameter int HI_OVH      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic [1:0]       speed_code,
  input  logic [CNT_W-1:0] std_hi_cnt,
  input  logic [CNT_W-1:0] std_lo_cnt,
  input  logic [CNT_W-1:0] fast_hi_cnt,
  input  logic [CNT_W-1:0] fast_lo_cnt,
  input  logic             scl_sense,
  output logic             scl_drive_low,
  output logic             bit_tick_fall,
  output logic             bit_tick_rise
);
  logic             line_hi;
  logic             idle;
  logic [CNT_W-1:0] hi_lim;
  logic [CNT_W-1:0] lo_lim;

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (scl_sense),
    .synced (line_hi)
  );

  scl_cnt_sel #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (idle),
    .speed_code (speed_code),
    .std_hi     (std_hi_cnt),
    .std_lo     (std_lo_cnt),
    .fast_hi    (fast_hi_cnt),
    .fast_lo    (fast_lo_cnt),
    .hi_lim     (hi_lim),
    .lo_lim     (lo_lim)
  );

  scl_phase_fsm #(
    .CNT_W       (CNT_W),
    .SYNC_STAGES (SYNC_STAGES),
    .HI_OVH      (HI_OVH)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (gen_en),
    .line_hi   (line_hi),
    .hi_lim    (hi_lim),
    .lo_lim    (lo_lim),
    .drive_low (scl_drive_low),
    .tick_fall (bit_tick_fall),
    .tick_rise (bit_tick_rise),
    .idle      (idle)
  );

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && idle) |=> (scl_drive_low && bit_tick_fall));
endmodule

// File: tb/test_scl_period_gen.sv
module test_scl_period_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gen_en = 1'b0;
  logic [1:0]  speed_code = 2'b01;
  logic [15:0] std_hi_cnt = 16'd10, std_lo_cnt = 16'd12;
  logic [15:0] fast_hi_cnt = 16'd7, fast_lo_cnt = 16'd9;
  logic        scl_drive_low, bit_tick_fall, bit_tick_rise;
  int          stretch_cfg = 0;
  int          stretch_left = 0;
  logic        prev_low = 1'b0;
  wire         scl_line = ~scl_drive_low & (stretch_left == 0);

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  scl_period_gen i_scl_period_gen (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .speed_code(speed_code),
    .std_hi_cnt(std_hi_cnt), .std_lo_cnt(std_lo_cnt),
    .fast_hi_cnt(fast_hi_cnt), .fast_lo_cnt(fast_lo_cnt),
    .scl_sense(scl_line), .scl_drive_low(scl_drive_low),
    .bit_tick_fall(bit_tick_fall), .bit_tick_rise(bit_tick_rise));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // target stretching the line after each release
  always @(negedge clk) begin
    if (prev_low && !scl_drive_low) stretch_left <= stretch_cfg;
    else if (stretch_left > 0)      stretch_left <= stretch_left - 1;
    prev_low <= scl_drive_low;
  end

  // behavioural reference: phase 0 idle, 1 low, 2 waiting for line, 3 high
  int m_ph = 0, m_left = 0, m_L = 6, m_H = 6;
  bit m_first = 0;
  bit l1 = 0, l2 = 0;
  function automatic int floor6(input int v);
    return (v < 6) ? 6 : v;
  endfunction
  always @(posedge clk) begin
    bit seen;
    seen = l2; l2 = l1; l1 = scl_line;
    m_first = 0;
    if (!rst_n) begin
      m_ph = 0; l1 = 0; l2 = 0;
    end else if (!gen_en) m_ph = 0;
    else case (m_ph)
      0: begin
        m_L = floor6(speed_code == 2'b10 ? fast_lo_cnt : std_lo_cnt);
        m_H = floor6(speed_code == 2'b10 ? fast_hi_cnt : std_hi_cnt);
        m_ph = 1; m_left = m_L + 1; m_first = 1;
      end
      1: if (m_left == 1) m_ph = 2; else m_left--;
      2: if (seen) begin m_ph = 3; m_left = m_H + 5; m_first = 1; end
      3: if (m_left == 1) begin m_ph = 1; m_left = m_L + 1; m_first = 1; end
         else m_left--;
      default: m_ph = 0;
    endcase
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(scl_drive_low == (m_ph == 1), {cur_req, "/model drive"}, scl_drive_low, m_ph == 1);
      check(bit_tick_fall == (m_ph == 1 && m_first), "R9 tick_fall", bit_tick_fall, m_ph == 1 && m_first);
      check(bit_tick_rise == (m_ph == 3 && m_first), "R9 tick_rise", bit_tick_rise, m_ph == 3 && m_first);
    end
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic measure(input int exp_lo, input int exp_hi, input string req);
    int n;
    n = 0;
    while (!bit_tick_fall && n < 2000) begin @(negedge clk); n++; end
    n = 0;
    while (scl_drive_low && n < 2000) begin n++; @(negedge clk); end
    check(n == exp_lo, {req, " low length"}, n, exp_lo);
    n = 0;
    while (!scl_drive_low && n < 2000) begin n++; @(negedge clk); end
    check(n == exp_hi, {req, " high length"}, n, exp_hi);
  endtask

  task automatic enable_and_check_start();
    gen_en = 1'b1;
    @(negedge clk);
    check(scl_drive_low == 1'b1, "R2 drive after enable", scl_drive_low, 1);
    check(bit_tick_fall == 1'b1, "R9 fall tick at start", bit_tick_fall, 1);
  endtask

  task automatic disable_and_check();
    gen_en = 1'b0;
    @(negedge clk);
    check(scl_drive_low == 1'b0, "R1 released after disable", scl_drive_low, 0);
    repeat (3) @(negedge clk);
    check(scl_drive_low == 0 && bit_tick_fall == 0 && bit_tick_rise == 0,
          "R1 quiet while off", scl_drive_low, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(scl_drive_low == 0 && bit_tick_fall == 0 && bit_tick_rise == 0,
          "R1 reset state", scl_drive_low, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(scl_drive_low == 0, "R1 idle after reset", scl_drive_low, 0);

    cur_req = "R3";
    enable_and_check_start();
    measure(13, 18, "R3/R4 standard");
    cur_req = "R8";
    std_lo_cnt = 16'd20; std_hi_cnt = 16'd30; speed_code = 2'b10;
    measure(13, 18, "R8 counts frozen while running");
    cur_req = "R1";
    disable_and_check();

    cur_req = "R6";
    enable_and_check_start();
    measure(10, 15, "R6 fast pair");
    disable_and_check();

    cur_req = "R7";
    fast_hi_cnt = 16'd2; fast_lo_cnt = 16'd0;
    enable_and_check_start();
    measure(7, 14, "R7 floor");
    disable_and_check();

    cur_req = "R5";
    speed_code = 2'b01; std_hi_cnt = 16'd10; std_lo_cnt = 16'd12;
    stretch_cfg = 5;
    enable_and_check_start();
    measure(13, 23, "R5 stretched");
    disable_and_check();
    stretch_cfg = 0;

    cur_req = "R6";
    speed_code = 2'b00;
    enable_and_check_start();
    measure(13, 18, "R6 code 00 standard");
    disable_and_check();
    speed_code = 2'b11;
    enable_and_check_start();
    measure(13, 18, "R6 code 11 standard");
    disable_and_check();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule